// File: doc/BRIEF.md
# Gated-Clock Serial ADC Capture Controller

This block paces a 16-bit successive-approximation converter and collects its results over a three-wire serial link. The converter drives that link as master. A sample-period counter in the system clock domain drives an active-low convert-start strobe at a fixed rate. The strobe does not depend on whether data is arriving. Each fall of the strobe makes the converter hold its input and begin a conversion.

The converter then returns the result on a bit clock that runs only while the word is being shifted out and stays idle between words. The bit clock, the frame sync and the data line all arrive asynchronously. The block passes them through a synchronizer and oversamples them, then assembles each word MSB first on the bit-clock rising edges.

Start-up follows a fixed sequence. The first word after enable is captured as 15 bits, and the length then changes to 16 bits without a pause. The first two words are thrown away, and every later word appears as a one-cycle valid pulse with its data. Dropping and raising the enable runs the start-up sequence again.

Top module: `adc_serial_capture`

## Requirements
- R1: While reset is active or `enable` is low, `conv_start_n` is high. After reset, `sample_valid` is low.
- R2: While enabled, `conv_start_n` goes low once per period and stays low for exactly `pulse_len` system clocks. A `pulse_len` value below 2 acts as 2.
- R3: Successive falling edges of `conv_start_n` are `sample_period` system clocks apart whenever `sample_period` exceeds the effective pulse length.
- R4: A word starts at the first bit-clock rising edge where `adc_sync_n` is low after a high-to-low change of `adc_sync_n`. The bit taken on that edge is the MSB. Each later rising edge shifts in one less significant bit, and `sample_data[15]` holds the MSB.
- R5: The first word after enable is 15 bits long. Every later word is 16 bits long.
- R6: The first two words completed after enable never raise `sample_valid`.
- R7: Each 16-bit word completed after the two discarded words raises `sample_valid` for exactly one cycle, with the word on `sample_data`.
- R8: A new high-to-low change of `adc_sync_n` during a word drops the partial word. The next qualifying rising edge starts a fresh word.
- R9: Bit-clock edges that arrive while no word is in progress and no frame-sync fall is pending are ignored. They produce no sample and do not disturb the next word.
- R10: Lowering `enable` and raising it again repeats the start-up sequence: a 15-bit word first, then two discarded words, then valid samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the strobe timer and capture; low clears the start-up sequence |
| sample_period | input | 16 | System clocks between convert-start falls |
| pulse_len | input | 8 | Low time of the convert-start strobe in system clocks (minimum 2) |
| conv_start_n | output | 1 | Active-low convert-start strobe |
| adc_sclk | input | 1 | Gated bit clock from the converter (asynchronous) |
| adc_sync_n | input | 1 | Active-low frame sync from the converter (asynchronous) |
| adc_sdata | input | 1 | Serial data from the converter, changing on falling bit-clock edges |
| sample_valid | output | 1 | One-cycle pulse marking an accepted sample |
| sample_data | output | 16 | Accepted sample, MSB in bit 15 |

## Verification
The assertions rely on three properties of the inputs. The bit clock runs no faster than a quarter of the system clock, so a 16-bit word spans many system cycles and two valid pulses can never be adjacent. The frame sync and data change only while the bit clock is low. `enable` is held steady across each convert-start pulse that the pulse-width property examines. The bench keeps within these limits: it drives the bit clock with four system clocks per half period, changes data only after a falling bit-clock edge, and lowers the frame sync half a bit period ahead of the first rising edge.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

   // Shortest convert-start low time the timer will ever produce
   localparam int unsigned MIN_PULSE = 2;

   // Start-up phase of the word sequencer
   typedef enum logic [1:0] {
      PH_FIRST = 2'd0,   // waiting for the short first word
      PH_DUMMY = 2'd1,   // full-length words still being discarded
      PH_LIVE  = 2'd2    // words are presented as samples
   } phase_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_cap_sync.sv
module adc_cap_sync #(
   parameter int unsigned WIDTH = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RESET_VAL;
               else        stage_q[s] <= async_in;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RESET_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/adc_cap_timer.sv
module adc_cap_timer
   import adc_cap_pkg::*;
#(
   parameter int unsigned PERIOD_W = 16,
   parameter int unsigned PULSE_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [PERIOD_W-1:0] sample_period,
   input  logic [PULSE_W-1:0]  pulse_len,
   output logic                conv_start_n
);

   localparam int unsigned CNT_W = max_u(PERIOD_W, PULSE_W) + 1;

   logic [CNT_W-1:0] pulse_ext, period_ext;
   logic [CNT_W-1:0] pulse_eff, period_eff;
   logic [CNT_W-1:0] cnt_q;
   logic             conv_q;
   logic             wrap;

   // Clamp the settings so the strobe always has a low and a high phase
   always_comb begin
      pulse_ext  = CNT_W'(pulse_len);
      period_ext = CNT_W'(sample_period);
      pulse_eff  = (pulse_ext < CNT_W'(MIN_PULSE)) ? CNT_W'(MIN_PULSE) : pulse_ext;
      period_eff = (period_ext <= pulse_eff) ? (pulse_eff + 1'b1) : period_ext;
      wrap       = (cnt_q >= (period_eff - 1'b1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         conv_q <= 1'b1;
      end else if (!enable) begin
         cnt_q  <= '0;
         conv_q <= 1'b1;
      end else begin
         conv_q <= !(cnt_q < pulse_eff);
         cnt_q  <= wrap ? '0 : (cnt_q + 1'b1);
      end
   end

   assign conv_start_n = conv_q;

endmodule

// File: rtl/adc_cap_deframer.sv
module adc_cap_deframer #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LEN_W  = 5,
   parameter bit          SAMPLE_ON_RISE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              sclk_s,
   input  logic              sync_n_s,
   input  logic              sdata_s,
   input  logic [LEN_W-1:0]  word_len,
   output logic              word_done,
   output logic [DATA_W-1:0] word_data
);

   logic              sclk_q, sync_n_q;
   logic              bit_edge, sync_fall, start;
   logic              pend_q, busy_q, done_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [DATA_W-1:0] shreg_q;

   // Bit clock edge selection
   generate
      if (SAMPLE_ON_RISE) begin : g_rise
         assign bit_edge = sclk_s & ~sclk_q;
      end else begin : g_fall
         assign bit_edge = ~sclk_s & sclk_q;
      end
   endgenerate

   assign sync_fall = ~sync_n_s & sync_n_q;
   assign start     = bit_edge & ~sync_n_s & (pend_q | sync_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         sync_n_q <= 1'b1;
      end else begin
         sclk_q   <= sclk_s;
         sync_n_q <= sync_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         cnt_q   <= '0;
         shreg_q <= '0;
      end else if (!enable) begin
         pend_q  <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         cnt_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (sync_fall) pend_q <= 1'b1;
         if (bit_edge) begin
            if (start) begin
               // Fresh frame: any partial word is dropped
               shreg_q <= {{(DATA_W-1){1'b0}}, sdata_s};
               cnt_q   <= LEN_W'(1);
               busy_q  <= 1'b1;
               pend_q  <= 1'b0;
            end else if (busy_q) begin
               shreg_q <= {shreg_q[DATA_W-2:0], sdata_s};
               cnt_q   <= cnt_q + 1'b1;
               if ((cnt_q + 1'b1) == word_len) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end

   assign word_done = done_q;
   assign word_data = shreg_q;

endmodule

// File: rtl/adc_cap_seq.sv
module adc_cap_seq
   import adc_cap_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned FIRST_W     = 15,
   parameter int unsigned DUMMY_WORDS = 2,
   parameter int unsigned LEN_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              word_done,
   input  logic [DATA_W-1:0] word_data,
   output logic [LEN_W-1:0]  word_len,
   output logic              sample_valid,
   output logic [DATA_W-1:0] sample_data
);

   localparam int unsigned DCNT_W = $clog2(DUMMY_WORDS + 1);

   phase_e            phase_q;
   logic [DCNT_W-1:0] drop_q;
   logic              valid_q;
   logic [DATA_W-1:0] data_q;
   logic              last_drop;

   assign last_drop = ((int'(drop_q) + 1) >= int'(DUMMY_WORDS));
   assign word_len  = (phase_q == PH_FIRST) ? LEN_W'(FIRST_W) : LEN_W'(DATA_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FIRST;
         drop_q  <= '0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (!enable) begin
         phase_q <= PH_FIRST;
         drop_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= word_done && (phase_q == PH_LIVE);
         if (word_done) begin
            if (phase_q == PH_LIVE) begin
               data_q <= word_data;
            end else begin
               drop_q  <= drop_q + 1'b1;
               phase_q <= last_drop ? PH_LIVE : PH_DUMMY;
            end
         end
      end
   end

   assign sample_valid = valid_q;
   assign sample_data  = data_q;

endmodule

// File: rtl/adc_serial_capture.sv
module adc_serial_capture
   import adc_cap_pkg::*;
#(
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned FIRST_W        = 15,
   parameter int unsigned DUMMY_WORDS    = 2,
   parameter int unsigned PERIOD_W       = 16,
   parameter int unsigned PULSE_W        = 8,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          SAMPLE_ON_RISE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [PERIOD_W-1:0] sample_period,
   input  logic [PULSE_W-1:0]  pulse_len,
   output logic                conv_start_n,
   input  logic                adc_sclk,
   input  logic                adc_sync_n,
   input  logic                adc_sdata,
   output logic                sample_valid,
   output logic [DATA_W-1:0]   sample_data
);

   localparam int unsigned LEN_W = $clog2(DATA_W + 1);

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (FIRST_W >= 2 && FIRST_W <= DATA_W) else $error("FIRST_W out of range");
      assert (DUMMY_WORDS >= 1) else $error("DUMMY_WORDS must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (PULSE_W >= 2 && PERIOD_W >= 2) else $error("timer widths too small");
   end

   logic [2:0]        pins_s;
   logic              word_done;
   logic [DATA_W-1:0] word_data;
   logic [LEN_W-1:0]  word_len;

   adc_cap_sync #(
      .WIDTH     (3),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (3'b010)
   ) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({adc_sclk, adc_sync_n, adc_sdata}),
      .sync_out (pins_s)
   );

   adc_cap_timer #(
      .PERIOD_W (PERIOD_W),
      .PULSE_W  (PULSE_W)
   ) i_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .sample_period (sample_period),
      .pulse_len     (pulse_len),
      .conv_start_n  (conv_start_n)
   );

   adc_cap_deframer #(
      .DATA_W         (DATA_W),
      .LEN_W          (LEN_W),
      .SAMPLE_ON_RISE (SAMPLE_ON_RISE)
   ) i_deframer (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .sclk_s    (pins_s[2]),
      .sync_n_s  (pins_s[1]),
      .sdata_s   (pins_s[0]),
      .word_len  (word_len),
      .word_done (word_done),
      .word_data (word_data)
   );

   adc_cap_seq #(
      .DATA_W      (DATA_W),
      .FIRST_W     (FIRST_W),
      .DUMMY_WORDS (DUMMY_WORDS),
      .LEN_W       (LEN_W)
   ) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .word_done    (word_done),
      .word_data    (word_data),
      .word_len     (word_len),
      .sample_valid (sample_valid),
      .sample_data  (sample_data)
   );

endmodule

// File: rtl/adc_cap_checker.sv
module adc_cap_checker #(
   parameter int unsigned DUMMY_WORDS = 2
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic conv_start_n,
   input logic sample_valid,
   input logic word_done
);

   int unsigned seen_q;

   // Words completed since enable, saturating just above the discard count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             seen_q <= 0;
      else if (!enable)                       seen_q <= 0;
      else if (word_done && seen_q <= DUMMY_WORDS) seen_q <= seen_q + 1;
   end

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> conv_start_n);

   assert_pulse_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(conv_start_n) && enable) |=> !conv_start_n);

   assert_dummy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> (seen_q > DUMMY_WORDS));

   assert_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid);

   assert_valid_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> $past(enable));

endmodule

bind adc_serial_capture adc_cap_checker #(.DUMMY_WORDS(DUMMY_WORDS)) i_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .conv_start_n (conv_start_n),
   .sample_valid (sample_valid),
   .word_done    (word_done)
);

// File: tb/test_adc_serial_capture.sv
`timescale 1ns/1ps
module test_adc_serial_capture;

   localparam int H = 4;  // system clocks per bit-clock half period
   localparam int NVEC = 6;
   localparam logic [15:0] VEC [NVEC] = '{16'hA5C3, 16'h0000, 16'hFFFF,
                                          16'h8001, 16'h1234, 16'h7FFE};

   logic        clk = 1'b0;
   logic        rst_n;
   logic        enable;
   logic [15:0] sample_period;
   logic [7:0]  pulse_len;
   logic        conv_start_n;
   logic        adc_sclk, adc_sync_n, adc_sdata;
   logic        sample_valid;
   logic [15:0] sample_data;

   int checks = 0;
   int errors = 0;
   int vcount = 0;
   logic [15:0] last_data = '0;

   always #5 clk = ~clk;

   adc_serial_capture i_adc_serial_capture (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .sample_period(sample_period), .pulse_len(pulse_len),
      .conv_start_n(conv_start_n),
      .adc_sclk(adc_sclk), .adc_sync_n(adc_sync_n), .adc_sdata(adc_sdata),
      .sample_valid(sample_valid), .sample_data(sample_data)
   );

   always @(negedge clk) begin
      if (sample_valid) begin
         vcount = vcount + 1;
         last_data = sample_data;
      end
   end

   task automatic check_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic measure(output int lo, output int per);
      lo = 0; per = 0;
      @(negedge clk);
      while (!conv_start_n) @(negedge clk);
      while (conv_start_n) @(negedge clk);
      while (!conv_start_n) begin lo++; per++; @(negedge clk); end
      while (conv_start_n) begin per++; @(negedge clk); end
   endtask

   task automatic send_frame(input logic [15:0] w, input int len, input int nbits);
      @(negedge clk);
      adc_sync_n = 1'b0;
      adc_sdata  = w[len-1];
      repeat (H) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         adc_sclk = 1'b1;
         repeat (H) @(negedge clk);
         adc_sclk = 1'b0;
         if (i + 1 < len) adc_sdata = w[len-2-i];
         repeat (H) @(negedge clk);
      end
      adc_sync_n = 1'b1;
      adc_sdata  = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic toggle_idle(input int n);
      for (int i = 0; i < n; i++) begin
         adc_sdata = i[0];
         adc_sclk = 1'b1; repeat (H) @(negedge clk);
         adc_sclk = 1'b0; repeat (H) @(negedge clk);
      end
      adc_sdata = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      int lo, per, base;
      rst_n = 1'b0; enable = 1'b0;
      sample_period = 16'd20; pulse_len = 8'd3;
      adc_sclk = 1'b0; adc_sync_n = 1'b1; adc_sdata = 1'b0;
      repeat (5) @(negedge clk);
      check_eq("R1 strobe in reset", int'(conv_start_n), 1);
      check_eq("R1 valid in reset", int'(sample_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_eq("R1 strobe after reset", int'(conv_start_n), 1);
      check_eq("R1 valid after reset", int'(sample_valid), 0);

      // Strobe timing
      enable = 1'b1;
      measure(lo, per);
      check_eq("R2 low time 3", lo, 3);
      check_eq("R3 period 20", per, 20);
      enable = 1'b0; pulse_len = 8'd1; sample_period = 16'd8;
      repeat (4) @(negedge clk);
      check_eq("R1 strobe while disabled", int'(conv_start_n), 1);
      enable = 1'b1;
      measure(lo, per);
      check_eq("R2 low time clamped to 2", lo, 2);
      check_eq("R3 period 8", per, 8);
      enable = 1'b0; sample_period = 16'd20; pulse_len = 8'd3;
      repeat (4) @(negedge clk);

      // Start-up sequence: 15-bit word, then a 16-bit word, both dropped
      enable = 1'b1;
      base = vcount;
      send_frame(16'h1ABC, 15, 15);
      check_eq("R5 R6 first 15-bit word dropped", vcount - base, 0);
      send_frame(16'h5555, 16, 16);
      check_eq("R6 second word dropped", vcount - base, 0);

      // Vector table
      for (int i = 0; i < NVEC; i++) begin
         send_frame(VEC[i], 16, 16);
         check_eq("R7 one valid per word", vcount - base, i + 1);
         check_eq("R4 data MSB first", int'(last_data), int'(VEC[i]));
      end

      // Mid-word frame restart
      base = vcount;
      send_frame(16'hDEAD, 16, 7);
      send_frame(16'h3C3C, 16, 16);
      check_eq("R8 partial word dropped count", vcount - base, 1);
      check_eq("R8 restarted word data", int'(last_data), 16'h3C3C);

      // Bit clock outside a frame
      base = vcount;
      toggle_idle(6);
      check_eq("R9 idle edges give no sample", vcount - base, 0);
      send_frame(16'hC0DE, 16, 16);
      check_eq("R9 next word count", vcount - base, 1);
      check_eq("R9 next word data", int'(last_data), 16'hC0DE);

      // Re-enable repeats start-up
      enable = 1'b0;
      repeat (6) @(negedge clk);
      enable = 1'b1;
      base = vcount;
      send_frame(16'h7FFF, 15, 15);
      send_frame(16'hFFFF, 16, 16);
      check_eq("R10 start-up words dropped again", vcount - base, 0);
      send_frame(16'h0F0F, 16, 16);
      check_eq("R10 first live word count", vcount - base, 1);
      check_eq("R10 R5 first live word data", int'(last_data), 16'h0F0F);

      finish_up();
   end

endmodule